// File: doc/BRIEF.md
# Serial Port Status Flag Unit

This unit keeps the three status flags of an asynchronous serial port: transmit holding register empty, receive data register full, and receive overrun. It takes strobes from three sides: the CPU register port (status read, status write with data), one DMA service strobe for each direction, and the serial datapath. From the datapath it takes a pulse when the transmit holding byte moves into the shift register, and a pulse with a byte when a received frame finishes without error.

Software can only clear a flag, and only in two steps. It must first read the status register and see the flag as 1. It must then write 0 to that bit. A hardware set event in the same cycle as a clear wins over the clear. The unit also holds the receive data register. This is why an overrun can throw away the new byte and keep the old one. The two interrupt requests are the flags gated by their enables.

The received byte arrives on a pulse that has no ready signal: the datapath cannot be held off. Back-pressure is therefore shown to software as the overrun flag, and the frame is dropped. All other pins are plain level or strobe controls.

Top module: `uart_status_flags`

## Requirements
- R1: After reset the status bits are 1 for transmit-empty and 0 for receive-full and overrun. The receive data register is 0 and both interrupt requests are low.
- R2: A status write with a bit at 1 never sets that flag. The flag keeps its value unless some other event in that cycle changes it.
- R3: The status bit map is bit0 = transmit-empty, bit1 = receive-full, bit2 = overrun. A status read loads a per-bit arm with the value that bit returned. A status write of 0 to a bit clears the flag only if that bit's arm is set. Every status write then clears all arms.
- R4: When the transmit enable is low, transmit-empty is 1 after the next edge. A holding-to-shift pulse also sets it.
- R5: A DMA transmit strobe (a holding register write) clears transmit-empty. A DMA receive strobe (a data register read) clears receive-full. Neither DMA strobe affects overrun.
- R6: A frame-done pulse with receive enabled and receive-full at 0 sets receive-full and loads the byte into the receive data register. Both are visible after the next edge.
- R7: A frame-done pulse with receive enabled and receive-full at 1 sets overrun. The receive data register and receive-full keep their values. Only a software clear removes overrun.
- R8: While receive is disabled, frame-done pulses are ignored, and receive-full, overrun and the receive data keep their values.
- R9: When a set event and a software or DMA clear hit the same flag in one cycle, the flag ends at 1.
- R10: The transmit request equals transmit-empty AND its interrupt enable. The receive request equals receive-full AND its interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 3 | Status write data (bit map of R3) |
| stat_rdata | output | 3 | Status flags (bit map of R3) |
| dma_tx_wr | input | 1 | DMA wrote the transmit holding register |
| dma_rx_rd | input | 1 | DMA read the receive data register |
| tx_load | input | 1 | Holding byte moved into the transmit shift register |
| rx_done | input | 1 | Frame completed without error |
| rx_byte | input | 8 | Byte of the completed frame |
| rx_data | output | 8 | Receive data register |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that every strobe is a single-cycle level sampled at the clock edge. They also assume that rx_byte is valid in the cycle rx_done is high. They do not assume the strobes are mutually exclusive, because the R9 priority rule is meant to cover collisions. The stimulus is driven just after each edge, so all inputs are stable at the next edge. A random phase deliberately makes reads, writes, DMA strobes and datapath pulses collide. The reference model is compared on every cycle.

// File: rtl/uart_sts_pkg.sv
package uart_sts_pkg;
  localparam int NFLAG   = 3;
  localparam int F_TXE   = 0;
  localparam int F_RXF   = 1;
  localparam int F_OVR   = 2;
  localparam int DATA_W  = 8;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/sts_arm_tracker.sv
module sts_arm_tracker #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_rd,
  input  logic         reg_wr,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] flags,
  output logic [N-1:0] sw_clr
);
  logic [N-1:0] arm;

  for (genvar i = 0; i < N; i++) begin : g_arm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      arm[i] <= 1'b0;
      else if (reg_wr) arm[i] <= 1'b0;
      else if (reg_rd) arm[i] <= flags[i];
    end
    assign sw_clr[i] = reg_wr & arm[i] & ~wdata[i];
  end
endmodule

// File: rtl/sts_flag_cell.sv
module sts_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST_VAL;
    else if (set_ev) q <= 1'b1;
    else if (clr_ev) q <= 1'b0;
  end
endmodule

// File: rtl/sts_rx_hold.sv
module sts_rx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
  import uart_sts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_ie,
  input  logic              rx_ie,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [NFLAG-1:0]  reg_wdata,
  output logic [NFLAG-1:0]  stat_rdata,
  input  logic              dma_tx_wr,
  input  logic              dma_rx_rd,
  input  logic              tx_load,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_irq,
  output logic              rx_irq
);
  flag_vec_t flags;
  flag_vec_t sw_clr;
  flag_vec_t set_ev;
  flag_vec_t clr_ev;
  logic      frame_ok;
  logic      accept;
  logic      overrun;

  assign frame_ok = rx_done & rx_en;
  assign accept   = frame_ok & ~flags[F_RXF];
  assign overrun  = frame_ok &  flags[F_RXF];

  always_comb begin
    set_ev         = '0;
    clr_ev         = sw_clr;
    set_ev[F_TXE]  = ~tx_en | tx_load;
    set_ev[F_RXF]  = accept;
    set_ev[F_OVR]  = overrun;
    clr_ev[F_TXE]  = sw_clr[F_TXE] | dma_tx_wr;
    clr_ev[F_RXF]  = sw_clr[F_RXF] | dma_rx_rd;
  end

  sts_arm_tracker #(.N(NFLAG)) u_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .reg_rd (reg_rd),
    .reg_wr (reg_wr),
    .wdata  (reg_wdata),
    .flags  (flags),
    .sw_clr (sw_clr)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam logic RV = (i == F_TXE);
    sts_flag_cell #(.RST_VAL(RV)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (set_ev[i]),
      .clr_ev (clr_ev[i]),
      .q      (flags[i])
    );
  end

  sts_rx_hold #(.W(DATA_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .din   (rx_byte),
    .dout  (rx_data)
  );

  assign stat_rdata = flags;
  assign tx_irq     = flags[F_TXE] & tx_ie;
  assign rx_irq     = flags[F_RXF] & rx_ie;
endmodule

// File: rtl/uart_status_flags_chk.sv
module uart_status_flags_chk
  import uart_sts_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              rx_en,
  input logic              rx_done,
  input logic [DATA_W-1:0] rx_byte,
  input logic              dma_rx_rd,
  input logic              reg_wr,
  input logic [NFLAG-1:0]  reg_wdata,
  input logic [NFLAG-1:0]  stat_rdata,
  input logic [DATA_W-1:0] rx_data
);
  AST_TXE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> stat_rdata[F_TXE]); // R4

  AST_RX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_en && !stat_rdata[F_RXF]) |=>
      (stat_rdata[F_RXF] && rx_data == $past(rx_byte))); // R6

  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_en && stat_rdata[F_RXF]) |=>
      (stat_rdata[F_OVR] && $stable(rx_data))); // R7

  AST_RX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en) |=> $stable(rx_data)); // R8

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[F_OVR] && !stat_rdata[F_OVR] && !(rx_done && rx_en))
      |=> !stat_rdata[F_OVR]); // R2

  AST_DMA_RX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rx_rd && !(rx_done && rx_en && !stat_rdata[F_RXF]))
      |=> !stat_rdata[F_RXF]); // R5
endmodule

bind uart_status_flags uart_status_flags_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .rx_en      (rx_en),
  .rx_done    (rx_done),
  .rx_byte    (rx_byte),
  .dma_rx_rd  (dma_rx_rd),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .stat_rdata (stat_rdata),
  .rx_data    (rx_data)
);

// File: tb/uart_status_flags_tb.sv
module uart_status_flags_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tx_en = 0, rx_en = 0, tx_ie = 0, rx_ie = 0;
  logic       reg_rd = 0, reg_wr = 0;
  logic [2:0] reg_wdata = 0;
  logic [2:0] stat_rdata;
  logic       dma_tx_wr = 0, dma_rx_rd = 0, tx_load = 0, rx_done = 0;
  logic [7:0] rx_byte = 0;
  logic [7:0] rx_data;
  logic       tx_irq, rx_irq;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  uart_status_flags u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .tx_ie(tx_ie), .rx_ie(rx_ie), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .stat_rdata(stat_rdata),
    .dma_tx_wr(dma_tx_wr), .dma_rx_rd(dma_rx_rd), .tx_load(tx_load),
    .rx_done(rx_done), .rx_byte(rx_byte), .rx_data(rx_data),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  // behavioural reference model
  bit m_txe = 1, m_rxf = 0, m_ovr = 0;
  bit m_arm[3];
  int m_data = 0;

  always @(posedge clk) begin
    bit clr_t, clr_r, clr_o, nt, nr, no;
    if (!rst_n) begin
      m_txe = 1; m_rxf = 0; m_ovr = 0; m_data = 0;
      foreach (m_arm[k]) m_arm[k] = 0;
    end else begin
      clr_t = reg_wr && m_arm[0] && !reg_wdata[0];
      clr_r = reg_wr && m_arm[1] && !reg_wdata[1];
      clr_o = reg_wr && m_arm[2] && !reg_wdata[2];
      nt = m_txe; nr = m_rxf; no = m_ovr;
      if (clr_t || dma_tx_wr) nt = 0;
      if (!tx_en || tx_load) nt = 1;
      if (clr_r || dma_rx_rd) nr = 0;
      if (clr_o) no = 0;
      if (rx_done && rx_en) begin
        if (m_rxf) no = 1;
        else begin nr = 1; m_data = rx_byte; end
      end
      if (reg_wr) foreach (m_arm[k]) m_arm[k] = 0;
      else if (reg_rd) begin
        m_arm[0] = m_txe; m_arm[1] = m_rxf; m_arm[2] = m_ovr;
      end
      m_txe = nt; m_rxf = nr; m_ovr = no;
    end
  end

  task automatic chk1(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk1("status", int'(stat_rdata), int'({m_ovr, m_rxf, m_txe}));
    chk1("rx_data", int'(rx_data), m_data);
    chk1("tx_irq R10", int'(tx_irq), int'(m_txe && tx_ie));
    chk1("rx_irq R10", int'(rx_irq), int'(m_rxf && rx_ie));
  endtask

  task automatic clear_strobes();
    reg_rd = 0; reg_wr = 0; reg_wdata = 0; dma_tx_wr = 0; dma_rx_rd = 0;
    tx_load = 0; rx_done = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    compare();
    clear_strobes();
  endtask

  task automatic frame(logic [7:0] b);
    rx_done = 1; rx_byte = b; step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1"; compare();
    // R1 expected values written out
    chk1("reset status R1", int'(stat_rdata), 1);
    step();
    tag = "R4"; tx_en = 0; step(); chk1("txe forced R4", int'(stat_rdata[0]), 1);
    tx_en = 1; tx_ie = 1; rx_en = 1; step();
    tag = "R5"; dma_tx_wr = 1; step(); chk1("dma tx clear R5", int'(stat_rdata[0]), 0);
    tag = "R4"; tx_load = 1; step(); chk1("tx_load set R4", int'(stat_rdata[0]), 1);
    tag = "R3"; reg_wr = 1; reg_wdata = 3'b000; step();
    chk1("no-read write keeps txe R3", int'(stat_rdata[0]), 1);
    reg_rd = 1; step(); reg_wr = 1; reg_wdata = 3'b000; step();
    chk1("read-then-write clears txe R3", int'(stat_rdata[0]), 0);
    tag = "R6"; rx_ie = 1; frame(8'hA5);
    chk1("rx accept R6", int'(rx_data), 8'hA5);
    tag = "R7"; frame(8'h3C);
    chk1("overrun keeps data R7", int'(rx_data), 8'hA5);
    chk1("overrun flag R7", int'(stat_rdata[2]), 1);
    dma_rx_rd = 1; step();
    chk1("dma leaves ovr R7", int'(stat_rdata[2]), 1);
    tag = "R2"; reg_wr = 1; reg_wdata = 3'b111; step();
    chk1("write 1 no set R2", int'(stat_rdata), 3'b100);
    reg_rd = 1; step(); reg_wr = 1; reg_wdata = 3'b011; step();
    chk1("ovr sw clear R3", int'(stat_rdata[2]), 0);
    tag = "R8"; frame(8'h11); rx_en = 0; frame(8'h22);
    chk1("rx disabled ignore R8", int'(rx_data), 8'h11);
    chk1("rx disabled keep rxf R8", int'(stat_rdata[1]), 1);
    rx_en = 1; dma_rx_rd = 1; step();
    tag = "R9"; dma_rx_rd = 1; rx_done = 1; rx_byte = 8'h77; step();
    chk1("set beats dma clear R9", int'(stat_rdata[1]), 1);
    tx_load = 1; dma_tx_wr = 1; step();
    chk1("set beats tx clear R9", int'(stat_rdata[0]), 1);
    tag = "R10"; tx_ie = 0; rx_ie = 1; step();
    chk1("irq gating R10", int'({tx_irq, rx_irq}), 2'b01);
    tag = "RAND";
    for (int n = 0; n < 3000; n++) begin
      tx_en = ($urandom_range(0, 15) != 0);
      rx_en = ($urandom_range(0, 7) != 0);
      tx_ie = 1'($urandom); rx_ie = 1'($urandom);
      reg_rd = ($urandom_range(0, 3) == 0);
      reg_wr = ($urandom_range(0, 3) == 0);
      reg_wdata = 3'($urandom);
      dma_tx_wr = ($urandom_range(0, 4) == 0);
      dma_rx_rd = ($urandom_range(0, 4) == 0);
      tx_load = ($urandom_range(0, 4) == 0);
      rx_done = ($urandom_range(0, 2) == 0);
      rx_byte = 8'($urandom);
      step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog %s: actual=hung expected=finished", tag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule